// File: doc/BRIEF.md
# Page Entry Permission and Referenced/Changed Checker

This block judges one access against the leaf entry that a page-table walk has already found. It takes the entry word, the kind of access (load, store or instruction fetch), whether the processor is in problem (user) state, and whether the check belongs to the first stage (effective to guest real) or the second stage (guest real to host real) of the translation. It also takes the key-0 deny bits of the data and instruction authority-mask registers. From these it produces the read/write/execute rights the page grants, a fault flag and a cause vector.

A separate output says whether the entry's referenced and changed bits already suit the access, so that the surrounding walker can decide to update the entry in memory. The block holds no state. Every output is a combinational function of the present inputs, so the caller can sample the result in the same cycle it presents the entry.

Top module: `page_perm_check`

## Requirements
- R1: The entry's authority bits decode into rights on `grant_o` (bit 0 read, bit 1 write, bit 2 execute). Read is granted when entry bit 2 or bit 1 is set, write when bit 1 is set, and execute when bit 0 is set.
- R2: For a first-stage check (`stage2_i`=0) in problem state (`prob_i`=1), an entry with bit 3 (privileged only) set grants no rights at all.
- R3: In three cases the rights are the decoded authority bits alone, and the mask inputs have no effect: problem state with bit 3 clear, an entry with bit 3 set in supervisor state, and any second-stage check.
- R4: In supervisor state on a first-stage check of an entry with bit 3 clear, the decoded rights are reduced by the masks. `dmask_i[1]` (data-mask bit 63) removes write, `dmask_i[0]` (data-mask bit 62) removes read, and `imask_i` (instruction-mask bit 62) removes execute.
- R5: `acc_i` encodes 0 as load, 1 as store, 2 as fetch, and 3 as a load. An access faults when the right it needs is missing from `grant_o`: read for a load, write for a store, execute for a fetch.
- R6: When entry bits [5:4] equal 2 (non-idempotent I/O), a fetch always faults with the guarded cause, whatever the rights. The other attribute values do not change the fault outcome.
- R7: `cause_o` bit 0 is guarded/no-execute, bit 1 is protection fault and bit 2 is store. A faulting fetch sets only bit 0. A faulting load sets only bit 1. A faulting store sets bits 1 and 2. With no fault, `cause_o` is zero.
- R8: Entry bit 8 is referenced and bit 7 is changed. `rc_upd_o` is 0 for a store only when both bits are set, and 0 for a load or fetch when bit 8 is set. Otherwise `rc_upd_o` is 1. This output does not depend on the fault outcome.
- R9: Entry bits other than 0–5, 7 and 8 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pte_i | input | PTE_W (64) | Leaf page entry word |
| acc_i | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 load |
| prob_i | input | 1 | 1 = problem (user) state |
| stage2_i | input | 1 | 1 = second-stage (partition) check |
| dmask_i | input | 2 | Data-mask key-0 deny bits: [1] write, [0] read |
| imask_i | input | 1 | Instruction-mask key-0 deny bit for execute |
| grant_o | output | 3 | Granted rights: [0] read, [1] write, [2] execute |
| fault_o | output | 1 | Access is not permitted |
| cause_o | output | 3 | Fault cause: [0] guarded, [1] protection, [2] store |
| rc_upd_o | output | 1 | Referenced/changed bits need an update for this access |

## Verification
The bench targets the privilege and stage cases. In those cases a wrong design would either apply the masks where they must be ignored, or leave a privileged page open to problem state on the first stage. It checks that read-only and execute-only entries fault on the right access kinds, and that a store fault carries both the protection and store bits. A design that swapped the cause bits or dropped the store flag shows up in those checks. It also drives the non-idempotent I/O attribute on fetch and non-fetch accesses, with the other attribute codes beside them. It drives entries with only one of the referenced and changed bits set, the reserved access code, and entries with high unused bits set. Each of those catches a design that tests the wrong bit or lets an ignored field leak into the result.

// File: rtl/page_perm_pkg.sv
// Shared definitions for the page entry permission checker: access kinds,
// right and cause bit positions, and entry field positions.
package page_perm_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    // Rights vector layout
    localparam int RIGHT_W = 3;
    localparam int RT_RD   = 0;
    localparam int RT_WR   = 1;
    localparam int RT_EX   = 2;

    // Cause vector layout
    localparam int CAUSE_W  = 3;
    localparam int CS_GUARD = 0;
    localparam int CS_PROT  = 1;
    localparam int CS_STORE = 2;

    // Entry field positions
    localparam int PB_EX     = 0;
    localparam int PB_RW     = 1;
    localparam int PB_RD     = 2;
    localparam int PB_PRIV   = 3;
    localparam int PB_ATT_LO = 4;
    localparam int PB_ATT_HI = 5;
    localparam int PB_CHG    = 7;
    localparam int PB_REF    = 8;
    localparam int AUTH_W    = PB_PRIV + 1;
    localparam int ATT_W     = PB_ATT_HI - PB_ATT_LO + 1;
    localparam logic [ATT_W-1:0] ATT_NIIO = 2'b10;

    // One-hot right needed by an access kind; the reserved code acts as a load.
    function automatic logic [RIGHT_W-1:0] needed_right(input logic [1:0] acc);
        logic [RIGHT_W-1:0] n;
        n = '0;
        case (acc)
            ACC_STORE: n[RT_WR] = 1'b1;
            ACC_FETCH: n[RT_EX] = 1'b1;
            default:   n[RT_RD] = 1'b1;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/pe_authority.sv
// Rights combiner.
// Turns the four authority bits of a leaf entry into a read/write/execute
// set and applies the privilege, stage and authority-mask rules.
// Assumes: purely combinational, no clock or reset; mask bits are deny bits.
module pe_authority
    import page_perm_pkg::*;
(
    input  logic [AUTH_W-1:0]  auth_i,
    input  logic               prob_i,
    input  logic               stage2_i,
    input  logic [1:0]         dmask_i,
    input  logic               imask_i,
    output logic [RIGHT_W-1:0] grant_o
);

    logic [RIGHT_W-1:0] base_rights;
    logic [RIGHT_W-1:0] deny_bits;
    logic               priv_page;
    logic               lock_out;
    logic               use_mask;

    // Decode the encoded authority into plain rights.
    always_comb begin
        base_rights        = '0;
        base_rights[RT_RD] = auth_i[PB_RD] | auth_i[PB_RW];
        base_rights[RT_WR] = auth_i[PB_RW];
        base_rights[RT_EX] = auth_i[PB_EX];
    end

    // Select which of the three combination rules applies.
    always_comb begin
        priv_page = auth_i[PB_PRIV];
        lock_out  = !stage2_i && prob_i && priv_page;
        use_mask  = !stage2_i && !prob_i && !priv_page;
    end

    // Gather mask deny bits in rights order.
    always_comb begin
        deny_bits        = '0;
        deny_bits[RT_RD] = dmask_i[0];
        deny_bits[RT_WR] = dmask_i[1];
        deny_bits[RT_EX] = imask_i;
    end

    // Per-right gating: lock-out clears, the mask removes denied rights.
    for (genvar g = 0; g < RIGHT_W; g++) begin : g_right
        assign grant_o[g] = base_rights[g] & !lock_out & !(use_mask & deny_bits[g]);
    end

    // Check the privileged-page lock-out and the mask-independence rule.
    always_comb begin
        if (!stage2_i && prob_i && auth_i[PB_PRIV]) begin
            AST_PRIV_LOCKOUT: assert (grant_o == '0)
                else $error("privileged page open to problem state"); // R2
        end
        if (stage2_i || prob_i || auth_i[PB_PRIV]) begin
            if (!(!stage2_i && prob_i && auth_i[PB_PRIV])) begin
                AST_NO_MASK_EFFECT: assert (grant_o[RT_WR] == auth_i[PB_RW])
                    else $error("mask altered write right"); // R3
            end
        end
        AST_WRITE_NEEDS_ENC: assert (!grant_o[RT_WR] || auth_i[PB_RW])
            else $error("write granted without write authority"); // R1
    end

endmodule

// File: rtl/pe_verdict.sv
// Fault decision and cause encoder.
// Compares the needed right with the granted set, folds in the guarded
// attribute for fetches, and forms the cause vector.
// Assumes: purely combinational; the reserved access code is a load.
module pe_verdict
    import page_perm_pkg::*;
(
    input  logic [1:0]         acc_i,
    input  logic [RIGHT_W-1:0] grant_i,
    input  logic               guard_attr_i,
    output logic               fault_o,
    output logic [CAUSE_W-1:0] cause_o
);

    logic [RIGHT_W-1:0] need;
    logic               is_fetch;
    logic               is_store;
    logic               denied;

    // Classify the access and test its right.
    always_comb begin
        need     = needed_right(acc_i);
        is_fetch = (acc_i == ACC_FETCH);
        is_store = (acc_i == ACC_STORE);
        denied   = ~|(need & grant_i);
    end

    // Combine the attribute and rights outcomes into the verdict.
    always_comb begin
        fault_o           = (guard_attr_i && is_fetch) || denied;
        cause_o           = '0;
        cause_o[CS_GUARD] = fault_o && is_fetch;
        cause_o[CS_PROT]  = fault_o && !is_fetch;
        cause_o[CS_STORE] = fault_o && is_store;
    end

    // Cause vector consistency with the fault flag and access kind.
    always_comb begin
        AST_CAUSE_ONLY_ON_FAULT: assert (fault_o || cause_o == '0)
            else $error("cause set without fault"); // R7
        AST_FAULT_HAS_CAUSE: assert (!fault_o || cause_o != '0)
            else $error("fault without cause"); // R5
        AST_STORE_FLAG_KIND: assert (!cause_o[CS_STORE] || acc_i == ACC_STORE)
            else $error("store flag on non-store"); // R7
        AST_ONE_KIND_BIT: assert ($onehot0(cause_o[CS_PROT:CS_GUARD]))
            else $error("guarded and protection both set"); // R7
    end

endmodule

// File: rtl/pe_refchg.sv
// Referenced/changed bit sufficiency test.
// Reports whether the entry's referenced and changed bits must be updated
// before the access may complete.
// Assumes: purely combinational; independent of the rights outcome.
module pe_refchg
    import page_perm_pkg::*;
(
    input  logic [1:0] acc_i,
    input  logic       ref_i,
    input  logic       chg_i,
    output logic       rc_upd_o
);

    // A store needs both bits; every other access needs only referenced.
    always_comb begin
        if (acc_i == ACC_STORE) rc_upd_o = !(ref_i && chg_i);
        else                    rc_upd_o = !ref_i;
    end

    // No update is ever reported unnecessary while referenced is clear.
    always_comb begin
        AST_REF_REQUIRED: assert (rc_upd_o || ref_i)
            else $error("update skipped with referenced clear"); // R8
    end

endmodule

// File: rtl/page_perm_check.sv
// Page entry permission and referenced/changed checker (top).
// Splits the leaf entry into its fields, computes granted rights, the
// fault verdict and the R/C update need.
// Assumes: purely combinational, no internal state; PTE_W > 9.
module page_perm_check
    import page_perm_pkg::*;
#(
    parameter int PTE_W = 64
) (
    input  logic [PTE_W-1:0]   pte_i,
    input  logic [1:0]         acc_i,
    input  logic               prob_i,
    input  logic               stage2_i,
    input  logic [1:0]         dmask_i,
    input  logic               imask_i,
    output logic [RIGHT_W-1:0] grant_o,
    output logic               fault_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic               rc_upd_o
);

    localparam int HIGH_LO = PB_REF + 1;

    logic [AUTH_W-1:0] auth;
    logic [ATT_W-1:0]  attr;
    logic              guard_attr;
    logic              unused_pte;

    // Extract the entry fields used by the checks.
    always_comb begin
        auth       = pte_i[AUTH_W-1:0];
        attr       = pte_i[PB_ATT_HI:PB_ATT_LO];
        guard_attr = (attr == ATT_NIIO);
    end

    // Fields of the entry that play no part in the checks.
    assign unused_pte = ^{pte_i[PTE_W-1:HIGH_LO], pte_i[PB_CHG-1]};

    pe_authority u_auth (
        .auth_i   (auth),
        .prob_i   (prob_i),
        .stage2_i (stage2_i),
        .dmask_i  (dmask_i),
        .imask_i  (imask_i),
        .grant_o  (grant_o)
    );

    pe_verdict u_verdict (
        .acc_i        (acc_i),
        .grant_i      (grant_o),
        .guard_attr_i (guard_attr),
        .fault_o      (fault_o),
        .cause_o      (cause_o)
    );

    pe_refchg u_rc (
        .acc_i    (acc_i),
        .ref_i    (pte_i[PB_REF]),
        .chg_i    (pte_i[PB_CHG]),
        .rc_upd_o (rc_upd_o)
    );

    // Guarded-attribute fetches always fault as guarded.
    always_comb begin
        if (pte_i[PB_ATT_HI:PB_ATT_LO] == ATT_NIIO && acc_i == ACC_FETCH) begin
            AST_GUARD_FETCH: assert (fault_o && cause_o[CS_GUARD])
                else $error("guarded fetch did not fault"); // R6
        end
    end

endmodule

// File: tb/page_perm_check_tb.sv
// Self-checking bench for page_perm_check: a vector table, then directed cases.
module page_perm_check_tb;

    localparam int PTE_W = 64;

    typedef struct packed {
        logic [11:0] pte;
        logic [1:0]  acc;
        logic        prob;
        logic        s2;
        logic [1:0]  dm;
        logic        im;
        logic [2:0]  grant;
        logic        fault;
        logic [2:0]  cause;
        logic        rc;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 18;
    // acc: 0 load, 1 store, 2 fetch, 3 load; grant {x,w,r}; cause {st,prot,guard}
    localparam vec_t VEC [NV] = '{
        '{12'h186, 2'd1, 1'b1, 1'b0, 2'b00, 1'b0, 3'b011, 1'b0, 3'b000, 1'b0, 4'd1},
        '{12'h104, 2'd0, 1'b1, 1'b0, 2'b00, 1'b0, 3'b001, 1'b0, 3'b000, 1'b0, 4'd1},
        '{12'h104, 2'd1, 1'b1, 1'b0, 2'b00, 1'b0, 3'b001, 1'b1, 3'b110, 1'b1, 4'd7},
        '{12'h10D, 2'd2, 1'b1, 1'b0, 2'b00, 1'b0, 3'b000, 1'b1, 3'b001, 1'b0, 4'd2},
        '{12'h10D, 2'd2, 1'b1, 1'b1, 2'b00, 1'b0, 3'b101, 1'b0, 3'b000, 1'b0, 4'd3},
        '{12'h10D, 2'd0, 1'b0, 1'b0, 2'b11, 1'b1, 3'b101, 1'b0, 3'b000, 1'b0, 4'd3},
        '{12'h187, 2'd0, 1'b0, 1'b0, 2'b01, 1'b0, 3'b110, 1'b1, 3'b010, 1'b0, 4'd4},
        '{12'h187, 2'd1, 1'b0, 1'b0, 2'b10, 1'b0, 3'b101, 1'b1, 3'b110, 1'b0, 4'd4},
        '{12'h187, 2'd2, 1'b0, 1'b0, 2'b00, 1'b1, 3'b011, 1'b1, 3'b001, 1'b0, 4'd4},
        '{12'h187, 2'd2, 1'b0, 1'b1, 2'b11, 1'b1, 3'b111, 1'b0, 3'b000, 1'b0, 4'd3},
        '{12'h1A7, 2'd2, 1'b1, 1'b0, 2'b00, 1'b0, 3'b111, 1'b1, 3'b001, 1'b0, 4'd6},
        '{12'h1A7, 2'd0, 1'b1, 1'b0, 2'b00, 1'b0, 3'b111, 1'b0, 3'b000, 1'b0, 4'd6},
        '{12'h1B7, 2'd2, 1'b1, 1'b0, 2'b00, 1'b0, 3'b111, 1'b0, 3'b000, 1'b0, 4'd6},
        '{12'h007, 2'd2, 1'b1, 1'b0, 2'b00, 1'b0, 3'b111, 1'b0, 3'b000, 1'b1, 4'd8},
        '{12'h087, 2'd0, 1'b1, 1'b0, 2'b00, 1'b0, 3'b111, 1'b0, 3'b000, 1'b1, 4'd8},
        '{12'h107, 2'd1, 1'b1, 1'b0, 2'b00, 1'b0, 3'b111, 1'b0, 3'b000, 1'b1, 4'd8},
        '{12'h181, 2'd3, 1'b1, 1'b0, 2'b00, 1'b0, 3'b100, 1'b1, 3'b010, 1'b0, 4'd5},
        '{12'h181, 2'd2, 1'b0, 1'b0, 2'b00, 1'b0, 3'b100, 1'b0, 3'b000, 1'b0, 4'd5}
    };

    logic             clk;
    logic             rst_n;
    logic [PTE_W-1:0] pte;
    logic [1:0]       acc;
    logic             prob;
    logic             s2;
    logic [1:0]       dm;
    logic             im;
    logic [2:0]       grant;
    logic             fault;
    logic [2:0]       cause;
    logic             rc;
    int               n_checks;
    int               n_errors;

    page_perm_check #(.PTE_W(PTE_W)) u_dut (
        .pte_i    (pte),
        .acc_i    (acc),
        .prob_i   (prob),
        .stage2_i (s2),
        .dmask_i  (dm),
        .imask_i  (im),
        .grant_o  (grant),
        .fault_o  (fault),
        .cause_o  (cause),
        .rc_upd_o (rc)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: got grant/fault/cause/rc %b expected %b", req, act, exp);
        end
    endtask

    task automatic apply(input logic [PTE_W-1:0] p, input logic [1:0] a, input logic pr,
                         input logic st, input logic [1:0] d, input logic i);
        @(posedge clk);
        pte = p; acc = a; prob = pr; s2 = st; dm = d; im = i;
        @(negedge clk);
    endtask

    initial begin
        n_checks = 0;
        n_errors = 0;
        rst_n = 1'b0;
        pte = '0; acc = 2'd0; prob = 1'b0; s2 = 1'b0; dm = 2'b00; im = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Reset-state inputs: empty entry, supervisor load -> no rights, load fault, R/C update
        @(negedge clk);
        check("R7 idle", {grant, fault, cause, rc}, {3'b000, 1'b1, 3'b010, 1'b1});

        for (int k = 0; k < NV; k++) begin
            apply({52'd0, VEC[k].pte}, VEC[k].acc, VEC[k].prob, VEC[k].s2, VEC[k].dm, VEC[k].im);
            check($sformatf("R%0d vec%0d", VEC[k].req, k), {grant, fault, cause, rc},
                  {VEC[k].grant, VEC[k].fault, VEC[k].cause, VEC[k].rc});
        end

        // R9: high entry bits and bit 6 set change nothing
        apply(64'hFFFF_F000_0000_0000 | 64'h1C6, 2'd1, 1'b1, 1'b0, 2'b00, 1'b0);
        check("R9 high bits", {grant, fault, cause, rc}, {3'b011, 1'b0, 3'b000, 1'b0});

        // R3: problem state, non-privileged page ignores all masks
        apply(64'h187, 2'd1, 1'b1, 1'b0, 2'b11, 1'b1);
        check("R3 prob masks", {grant, fault, cause, rc}, {3'b111, 1'b0, 3'b000, 1'b0});

        // R4: all masks set in supervisor -> nothing granted, store fault
        apply(64'h187, 2'd1, 1'b0, 1'b0, 2'b11, 1'b1);
        check("R4 all masks", {grant, fault, cause, rc}, {3'b000, 1'b1, 3'b110, 1'b0});

        // R6: attribute 1 on fetch does not fault
        apply(64'h197, 2'd2, 1'b1, 1'b0, 2'b00, 1'b0);
        check("R6 attr1", {grant, fault, cause, rc}, {3'b111, 1'b0, 3'b000, 1'b0});

        // R6: guarded attribute on store does not fault when write is granted
        apply(64'h1A7, 2'd1, 1'b0, 1'b1, 2'b00, 1'b0);
        check("R6 attr2 store", {grant, fault, cause, rc}, {3'b111, 1'b0, 3'b000, 1'b0});

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule